// File: doc/BRIEF.md
# Interval Timer Register Access Unit

This block is the host-side register front end for a three-channel interval timer. The host bus is 8 bits wide with a 2-bit address. Addresses 0 to 2 are the data ports of channels 0 to 2, and address 3 is the command port. Each channel's counting core supplies two inputs: a live 16-bit count and its output bit. In return the unit gives each channel a one-cycle load strobe and a 17-bit reload value.

The unit decodes three kinds of command written to the command port: configuration words, single-channel count-latch commands and multi-channel read-back commands. It keeps one count latch and one status latch per channel, and each latch captures only once until it is read out. Every channel has its own read byte toggle and its own write byte toggle, so 16-bit counts can move over the 8-bit bus in low-only, high-only or low-then-high order. Reads are combinational on `rd_data` while `rd_en` is high. Their side effects (releasing a latch, advancing a toggle) take place at the clock edge.

Top module: `tmr_regif`

## Requirements
- R1: After reset, no latch is pending and every channel is in low-byte-only access. Each `load_val` lane reads 65536, `load_stb` is 0, and a data-port read returns the low byte of the live count.
- R2: A write to address 3 with bits 7:6 = channel 0..2 and a nonzero bits 5:4 does four things to that channel. It stores the access mode from bits 5:4 (1 = low only, 2 = high only, 3 = low then high), the operating mode from bits 3:1 and the BCD flag from bit 0. It also sets both the read toggle and the write toggle back to the low byte.
- R3: A command-port write with bits 5:4 = 0 latches that channel's live count and leaves its mode unchanged. While a count latch is pending, any further count-latch request leaves the held value untouched.
- R4: A command-port write with bits 7:6 = 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low latches the count of each selected channel, and bit 4 low latches its status. A status latch that is still pending is not replaced.
- R5: The status byte is built as follows: bit 7 is the channel output, bit 6 is 0, bits 5:4 hold the access mode, bits 3:1 hold the operating mode and bit 0 holds the BCD flag.
- R6: A data-port read returns a pending status byte first and clears it. If no status is pending, it returns a pending count latch. If neither is pending, it returns the live count.
- R7: How a latched count is read depends on the access mode. In low-only mode, one read returns bits 7:0 and releases the latch. In high-only mode, one read returns bits 15:8 and releases it. In word mode, the first read returns the low byte, the second read returns the high byte and then releases the latch.
- R8: When no latch is pending, reads return the low byte of the live count in low-only mode and the high byte in high-only mode. In word mode they alternate low, high, low and so on, starting from the low byte.
- R9: A data write loads the channel as follows. In low-only mode it loads {0, byte}. In high-only mode it loads {byte, 0}. In word mode the first byte is held and the second byte loads {second, first}. The channel's `load_stb` pulses for exactly the cycle after the write that completes the value, and `load_val` holds between loads.
- R10: A 16-bit load value of 0 appears on `load_val` as 65536.
- R11: A read of address 3 returns 0xFF and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | 0..2 data port of a channel, 3 command port |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Host read byte, valid while rd_en is high |
| live_count | input | 48 | Live counts, channel i in bits 16i+15:16i |
| chan_out | input | 3 | Output bit of each channel's core |
| load_stb | output | 3 | One-cycle reload strobe per channel |
| load_val | output | 51 | Reload value, channel i in bits 17i+16:17i |

## Verification
Random traffic mixes configuration words in all four access codes, read-back commands with every selection and latch-disable combination, data writes and reads, and reads of the command port. While this traffic runs, the live counts and output bits change on every cycle. Because the live counts keep moving, a latched value can be told apart from a fresh capture and from a live read. The read-back and latch commands are often repeated before any read, which exposes a latch that overwrites instead of capturing once. Directed sequences cover the remaining corners: status taking priority over a latched count in word mode, a write of zero, a word write that is interrupted by a configuration word, and a command-port read placed between the two halves of a latched word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH   = 3;
  localparam int DW    = 8;
  localparam int CW    = 2 * DW;
  localparam int LW    = CW + 1;

  typedef enum logic [1:0] {
    ACC_NULL = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  // 16-bit load of zero stands for a full 2^16 period
  function automatic logic [LW-1:0] reload_of(input logic [CW-1:0] v);
    reload_of = (v == '0) ? (LW'(1) << CW) : {1'b0, v};
  endfunction

  function automatic logic [DW-1:0] status_of(input logic o, input acc_e a,
                                              input logic [2:0] m, input logic b);
    status_of = {o, 1'b0, a, m, b};
  endfunction
endpackage

// File: rtl/tmr_cmd_dec.sv
module tmr_cmd_dec
  import tmr_pkg::*;
(
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [1:0]     addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] cfg_wr,
  output logic [NCH-1:0] cnt_lat,
  output logic [NCH-1:0] st_lat,
  output logic [NCH-1:0] data_wr,
  output logic [NCH-1:0] data_rd
);
  logic cmd_wr, rb_cmd;
  assign cmd_wr = wr_en && (addr == 2'd3);
  assign rb_cmd = cmd_wr && (wr_data[7:6] == 2'd3);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel        = cmd_wr && !rb_cmd && (wr_data[7:6] == 2'(i));
    assign cfg_wr[i]  = sel && (wr_data[5:4] != 2'd0);
    assign cnt_lat[i] = (sel && (wr_data[5:4] == 2'd0)) ||
                        (rb_cmd && wr_data[1+i] && !wr_data[5]);
    assign st_lat[i]  = rb_cmd && wr_data[1+i] && !wr_data[4];
    assign data_wr[i] = wr_en && (addr == 2'(i));
    assign data_rd[i] = rd_en && (addr == 2'(i));
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cnt_lat_cmd,
  input  logic          st_lat_cmd,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] live_cnt,
  input  logic          out_bit,
  output logic [DW-1:0] rd_byte,
  output logic          load_stb,
  output logic [LW-1:0] load_val
);
  acc_e          acc, lat_st;
  logic [2:0]    op_mode;
  logic          bcd, rd_hi, wr_hi, st_pend;
  logic [DW-1:0] wr_lo, st_byte;
  logic [CW-1:0] lat_val;

  // read mux: status, then latched count, then live count
  always_comb begin
    if (st_pend)                rd_byte = st_byte;
    else if (lat_st == ACC_HI)  rd_byte = lat_val[CW-1:DW];
    else if (lat_st != ACC_NULL) rd_byte = lat_val[DW-1:0];
    else if (acc == ACC_HI)     rd_byte = live_cnt[CW-1:DW];
    else if (acc == ACC_WORD && rd_hi) rd_byte = live_cnt[CW-1:DW];
    else                        rd_byte = live_cnt[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= ACC_LO;
      lat_st   <= ACC_NULL;
      op_mode  <= '0;
      bcd      <= 1'b0;
      rd_hi    <= 1'b0;
      wr_hi    <= 1'b0;
      st_pend  <= 1'b0;
      wr_lo    <= '0;
      st_byte  <= '0;
      lat_val  <= '0;
      load_stb <= 1'b0;
      load_val <= reload_of('0);
    end else begin
      load_stb <= 1'b0;
      if (data_rd) begin
        if (st_pend)                 st_pend <= 1'b0;
        else if (lat_st == ACC_WORD) lat_st  <= ACC_HI;
        else if (lat_st != ACC_NULL) lat_st  <= ACC_NULL;
        else if (acc == ACC_WORD)    rd_hi   <= ~rd_hi;
      end
      if (cnt_lat_cmd && lat_st == ACC_NULL) begin
        lat_val <= live_cnt;
        lat_st  <= acc;
      end
      if (st_lat_cmd && !st_pend) begin
        st_pend <= 1'b1;
        st_byte <= status_of(out_bit, acc, op_mode, bcd);
      end
      if (data_wr) begin
        unique case (acc)
          ACC_HI: begin
            load_stb <= 1'b1;
            load_val <= reload_of({wr_data, {DW{1'b0}}});
          end
          ACC_WORD: begin
            if (!wr_hi) begin
              wr_lo <= wr_data;
              wr_hi <= 1'b1;
            end else begin
              wr_hi    <= 1'b0;
              load_stb <= 1'b1;
              load_val <= reload_of({wr_data, wr_lo});
            end
          end
          default: begin
            load_stb <= 1'b1;
            load_val <= reload_of({{DW{1'b0}}, wr_data});
          end
        endcase
      end
      if (cfg_wr) begin
        acc     <= acc_e'(wr_data[5:4]);
        op_mode <= wr_data[3:1];
        bcd     <= wr_data[0];
        rd_hi   <= 1'b0;
        wr_hi   <= 1'b0;
      end
    end
  end

  // R2: configuration restarts both byte toggles
  a_r2_cfg_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !data_wr && !data_rd) |=> (!rd_hi && !wr_hi));
  // R3: a pending count latch is never recaptured
  a_r3_latch_once: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_lat_cmd && lat_st != ACC_NULL && !data_rd) |=> $stable(lat_val));
  // R4: a pending status latch is never replaced
  a_r4_status_once: assert property (@(posedge clk) disable iff (!rst_n)
    (st_lat_cmd && st_pend && !data_rd) |=> $stable(st_byte));
  // R6: a status read leaves the count latch pending
  a_r6_status_first: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && st_pend && !cnt_lat_cmd) |=> (!st_pend || st_lat_cmd) && $stable(lat_st));
  // R9: a load strobe follows only a data write
  a_r9_stb_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(data_wr));
  // R10: the reload value never reads zero
  a_r10_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> (load_val != '0));
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [NCH*CW-1:0] live_count,
  input  logic [NCH-1:0]    chan_out,
  output logic [NCH-1:0]    load_stb,
  output logic [NCH*LW-1:0] load_val
);
  logic [NCH-1:0] cfg_wr, cnt_lat, st_lat, data_wr, data_rd;
  logic [DW-1:0]  ch_rd [NCH];

  tmr_cmd_dec u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .cfg_wr(cfg_wr), .cnt_lat(cnt_lat), .st_lat(st_lat),
    .data_wr(data_wr), .data_rd(data_rd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    tmr_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr[i]), .cnt_lat_cmd(cnt_lat[i]), .st_lat_cmd(st_lat[i]),
      .data_wr(data_wr[i]), .data_rd(data_rd[i]), .wr_data(wr_data),
      .live_cnt(live_count[i*CW +: CW]), .out_bit(chan_out[i]),
      .rd_byte(ch_rd[i]), .load_stb(load_stb[i]),
      .load_val(load_val[i*LW +: LW])
    );
  end

  always_comb begin
    rd_data = '1;
    for (int i = 0; i < NCH; i++)
      if (addr == 2'(i)) rd_data = ch_rd[i];
  end

  // R11: a command-port read never touches a channel
  a_r11_cmd_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |-> (data_rd == '0 && rd_data == 8'hFF));
  // R2: at most one channel takes a configuration word
  a_r2_one_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_wr));
endmodule

// File: tb/tmr_regif_tb.sv
module tmr_regif_tb;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [1:0]  addr = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  rd_data;
  logic [47:0] live_count = 0;
  logic [2:0]  chan_out = 0;
  logic [2:0]  load_stb;
  logic [50:0] load_val;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_regif u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .live_count(live_count),
    .chan_out(chan_out), .load_stb(load_stb), .load_val(load_val));

  // bench model state
  int          m_acc[3], m_lat[3];
  logic [2:0]  m_mode[3];
  bit          m_bcd[3], m_rdhi[3], m_wrhi[3], m_stp[3];
  logic [7:0]  m_wlo[3], m_stb[3];
  logic [15:0] m_latv[3];
  logic [16:0] m_ld[3];
  bit          m_stbexp[3];

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] live(int c);
    return live_count[c*16 +: 16];
  endfunction

  function automatic logic [16:0] as_load(logic [15:0] v);
    return (v == 0) ? 17'h10000 : {1'b0, v};
  endfunction

  function automatic void m_reset();
    for (int c = 0; c < 3; c++) begin
      m_acc[c] = 1; m_lat[c] = 0; m_mode[c] = 0; m_bcd[c] = 0;
      m_rdhi[c] = 0; m_wrhi[c] = 0; m_stp[c] = 0; m_wlo[c] = 0;
      m_stb[c] = 0; m_latv[c] = 0; m_ld[c] = 17'h10000;
    end
  endfunction

  function automatic void m_latch(int c);
    if (m_lat[c] == 0) begin m_latv[c] = live(c); m_lat[c] = m_acc[c]; end
  endfunction

  function automatic void m_write(logic [1:0] a, logic [7:0] d);
    if (a == 3) begin
      if (d[7:6] == 3) begin
        for (int c = 0; c < 3; c++) if (d[1+c]) begin
          if (!d[5]) m_latch(c);
          if (!d[4] && !m_stp[c]) begin
            m_stp[c] = 1;
            m_stb[c] = {chan_out[c], 1'b0, 2'(m_acc[c]), m_mode[c], m_bcd[c]};
          end
        end
      end else if (d[5:4] == 0) m_latch(d[7:6]);
      else begin
        m_acc[d[7:6]] = d[5:4]; m_mode[d[7:6]] = d[3:1]; m_bcd[d[7:6]] = d[0];
        m_rdhi[d[7:6]] = 0; m_wrhi[d[7:6]] = 0;
      end
    end else begin
      int c = a;
      if (m_acc[c] == 1) begin m_ld[c] = as_load({8'h0, d}); m_stbexp[c] = 1; end
      else if (m_acc[c] == 2) begin m_ld[c] = as_load({d, 8'h0}); m_stbexp[c] = 1; end
      else if (!m_wrhi[c]) begin m_wlo[c] = d; m_wrhi[c] = 1; end
      else begin m_ld[c] = as_load({d, m_wlo[c]}); m_wrhi[c] = 0; m_stbexp[c] = 1; end
    end
  endfunction

  function automatic logic [7:0] m_read(logic [1:0] a, output string req);
    int c = a;
    logic [7:0] r;
    if (a == 3) begin req = "R11"; return 8'hFF; end
    if (m_stp[c]) begin req = "R6"; m_stp[c] = 0; return m_stb[c]; end
    if (m_lat[c] != 0) begin
      req = "R7";
      if (m_lat[c] == 2) begin m_lat[c] = 0; return m_latv[c][15:8]; end
      r = m_latv[c][7:0];
      m_lat[c] = (m_lat[c] == 3) ? 2 : 0;
      return r;
    end
    req = "R8";
    if (m_acc[c] == 2) return live(c)[15:8];
    if (m_acc[c] == 3) begin
      r = m_rdhi[c] ? live(c)[15:8] : live(c)[7:0];
      m_rdhi[c] = !m_rdhi[c];
      return r;
    end
    return live(c)[7:0];
  endfunction

  task automatic op(bit we, bit re, logic [1:0] a, logic [7:0] d);
    string rq;
    logic [7:0] e;
    @(negedge clk);
    live_count = {$urandom, $urandom};
    chan_out = 3'($urandom);
    wr_en = we; rd_en = re; addr = a; wr_data = d;
    for (int c = 0; c < 3; c++) m_stbexp[c] = 0;
    #1;
    if (re) begin e = m_read(a, rq); chk(rq, rd_data, e); end
    if (we) m_write(a, d);
    @(posedge clk); #1;
    for (int c = 0; c < 3; c++) begin
      chk("R9 strobe", load_stb[c], m_stbexp[c]);
      chk("R10 value", load_val[c*17 +: 17], m_ld[c]);
    end
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    for (int c = 0; c < 3; c++) begin
      chk("R1 load_val", load_val[c*17 +: 17], 17'h10000);
      chk("R1 load_stb", load_stb[c], 0);
    end
    for (int c = 0; c < 3; c++) op(0, 1, 2'(c), 0);
    // R10: zero in low-only mode becomes 65536; then a plain byte
    op(1, 0, 0, 8'h00);
    op(1, 0, 0, 8'h5A);
    // R9: word write, interrupted by a config word, then completed
    op(1, 0, 3, 8'b01_11_010_0);
    op(1, 0, 1, 8'h34);
    op(1, 0, 3, 8'b01_11_011_1);
    op(1, 0, 1, 8'h78);
    op(1, 0, 1, 8'h12);
    // R9 high-only
    op(1, 0, 3, 8'b10_10_000_0);
    op(1, 0, 2, 8'h9C);
    // R6/R7/R5: word latch plus status, status first, repeated latches ignored
    op(1, 0, 3, 8'b11_00_1110);
    op(1, 0, 3, 8'b11_00_1110);
    op(1, 0, 3, 8'b01_00_0000);
    op(0, 1, 1, 0);
    op(0, 1, 1, 0);
    op(0, 1, 3, 0); // R11 between the halves
    op(0, 1, 1, 0);
    op(0, 1, 1, 0);
    // R4: status only, count only
    op(1, 0, 3, 8'b11_10_0010);
    op(1, 0, 3, 8'b11_01_0010);
    op(0, 1, 0, 0);
    op(0, 1, 0, 0);
    op(0, 1, 0, 0);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int kind = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      if (kind < 2) op(1, 0, 3, {2'($urandom_range(0, 2)), d[5:0]});
      else if (kind < 4) op(1, 0, 3, {2'b11, d[5:0]});
      else if (kind < 6) op(1, 0, 2'($urandom_range(0, 2)), d);
      else if (kind < 9) op(0, 1, 2'($urandom_range(0, 2)), 0);
      else op(0, 1, 3, 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule